// File: doc/BRIEF.md
# Serial SAR ADC Host Sequencer

This block runs one conversion on an external multiplexed 8-bit successive-approximation converter that talks over a four-wire serial link: an active-low select, a serial clock, a command line towards the converter and a data line back from it. The system side hands over a request with a channel number and a single-ended or differential flag. The block then selects the converter and generates the serial clock from the system clock at a programmable rate. It sends a start bit and a multiplexer address word, lets one serial cycle pass for the multiplexer to settle, and shifts in the 8-bit result most significant bit first. The result is then presented with a one-cycle strobe.

The number of analog inputs on the converter (2, 4 or 8) is a parameter, and it sets the length of the address word. In differential mode, the requested channel names the input that is to be treated as positive. Its pair partner, the other channel of the same adjacent even/odd pair, is the negative input. The serial clock rate is set on an input in units of system clocks per half period, so that the clock can be kept inside the converter's permitted frequency range whatever the system clock is.

Top module: `sadc_host`

## Requirements
- R1: During and right after reset, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_di` is 0, and both `busy` and `done` are 0.
- R2: A `req_valid` sampled while `busy` is 0 is accepted, and `busy` is 1 from the next cycle. Between the rise of `adc_cs_n` that ends one transaction and its fall for the next, at least 2·H system clocks pass. H is the value of `half_period`, with 0 treated as 1.
- R3: While `adc_cs_n` is 0, every low and every high phase of `adc_sclk` lasts exactly H system clocks, and `adc_sclk` is 0 whenever `adc_cs_n` is 1.
- R4: `adc_cs_n` falls with `adc_sclk` low and `adc_di` already 1. That 1 is the start bit, taken on the first rising edge. `adc_di` never changes in the cycle where `adc_sclk` rises.
- R5: After the start bit, one bit is sent per rising edge, MSB first, forming a word of log2(NUM_CH)+1 bits. The first bit is 1 for single-ended and 0 for differential. The second bit is `req_ch[0]`. The remaining bits are `req_ch` with its lowest bit dropped (the pair index), sent MSB first.
- R6: The serial cycle right after the last address bit is a settling cycle, and the value on `adc_do` during it does not reach `result`.
- R7: The next 8 serial cycles deliver the result MSB first. Each bit is sampled from `adc_do` in the system cycle where `adc_sclk` rises, after the converter has driven that bit following the preceding falling edge.
- R8: At the end of the high phase of the eighth data cycle, `adc_sclk` falls and `adc_cs_n` rises in the same cycle. `done` is 1 for exactly that one cycle, and `result` holds the new value until the next `done`.
- R9: A request made while `busy` is 1 is ignored: it neither alters the running conversion nor starts another one. `busy` is 0 in the `done` cycle, so a request made in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | System clocks per serial clock half period (0 acts as 1) |
| req_valid | input | 1 | Conversion request |
| req_ch | input | log2(NUM_CH) | Channel number; positive input in differential mode |
| req_diff | input | 1 | 1 selects differential mode |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle strobe: `result` is new |
| result | output | DATA_W | Last converted value |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_di | output | 1 | Start bit and address towards the converter |
| adc_do | input | 1 | Serial data from the converter |

## Verification
The result strobe of one transaction and the acceptance of the next request can fall in the same system cycle. This happens because `busy` already reads 0 while `done` is high. The bench provokes the overlap by raising `req_valid` inside the very cycle in which it observes `done`. It then judges three things: the first result, the second result, and that the deselect time between the two transactions still reaches 2·H. A second overlap, a request issued in the middle of a running conversion, is judged by the unchanged result and by the select line staying high after `done`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_RUN  = 2'd2
   } seq_st_e;

   // half periods spent deselected after a request is taken
   localparam int unsigned LEAD_HALVES = 2;

endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_period,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   // zero is treated as a half period of one system clock
   assign lim  = (half_period == '0) ? '0 : half_period - 1'b1;
   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || cnt_q == lim)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R3: half periods longer than one clock never tick back to back
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0 && $stable(half_period)) |=> !tick)
      else $error("tick spacing shorter than the half period");

endmodule

// File: rtl/sadc_addr.sv
module sadc_addr #(
   parameter int unsigned CH_W = 3
) (
   input  logic [CH_W-1:0] ch,
   input  logic            diff,
   output logic [CH_W:0]   word
);

   // word: mode bit, odd/sign bit, then pair index MSB first
   generate
      if (CH_W == 1) begin : g_two
         assign word = {~diff, ch[0]};
      end else begin : g_many
         assign word = {~diff, ch[0], ch[CH_W-1:1]};
      end
   endgenerate

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   input  logic              commit,
   output logic [DATA_W-1:0] result
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         n_q    <= '0;
         result <= '0;
      end else begin
         if (shift_en) begin
            sh_q <= {sh_q[DATA_W-2:0], din};
            n_q  <= n_q + 1'b1;
         end
         if (commit) begin
            result <= sh_q;
            n_q    <= '0;
         end
      end
   end

   // R7: a result is only published after exactly DATA_W samples
   assert_commit_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (n_q == CNT_W'(DATA_W)))
      else $error("result committed with wrong sample count");

   // R6: no sample beyond the data field (settle or extra cycles)
   assert_shift_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> (n_q < CNT_W'(DATA_W)))
      else $error("sample taken outside the data field");

endmodule

// File: rtl/sadc_host.sv
module sadc_host #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DIV_W-1:0]           half_period,
   input  logic                       req_valid,
   input  logic [$clog2(NUM_CH)-1:0]  req_ch,
   input  logic                       req_diff,
   output logic                       busy,
   output logic                       done,
   output logic [DATA_W-1:0]          result,
   output logic                       adc_cs_n,
   output logic                       adc_sclk,
   output logic                       adc_di,
   input  logic                       adc_do
);
   import sadc_pkg::*;

   localparam int unsigned CH_W       = $clog2(NUM_CH);
   localparam int unsigned ADDR_W     = CH_W + 1;
   localparam int unsigned NTX        = ADDR_W + 1;
   localparam int unsigned FIRST_HALF = 2 * (NTX + 1) + 1;
   localparam int unsigned LAST_HALF  = 2 * (NTX + DATA_W) + 1;
   localparam int unsigned HI_W       = $clog2(LAST_HALF + 2);

   generate
      if (NUM_CH != 2 && NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
         $error("NUM_CH must be 2, 4 or 8");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   seq_st_e          st_q;
   logic [HI_W-1:0]  hidx_q;
   logic [HI_W-1:0]  hnext;
   logic [ADDR_W-1:0] tx_q;
   logic [ADDR_W-1:0] word;
   logic             cs_n_q;
   logic             sclk_q;
   logic             di_q;
   logic             done_q;
   logic             tick;
   logic             last_half;
   logic             sample_en;
   logic             commit;

   sadc_addr #(.CH_W(CH_W)) u_addr (
      .ch   (req_ch),
      .diff (req_diff),
      .word (word)
   );

   sadc_tick #(.DIV_W(DIV_W)) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (st_q != ST_IDLE),
      .half_period (half_period),
      .tick        (tick)
   );

   assign hnext     = hidx_q + 1'b1;
   assign last_half = (hidx_q == HI_W'(LAST_HALF));
   assign commit    = (st_q == ST_RUN) && tick && last_half;
   assign sample_en = (st_q == ST_RUN) && tick && !last_half && hnext[0]
                      && (hnext >= HI_W'(FIRST_HALF));

   sadc_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sample_en),
      .din      (adc_do),
      .commit   (commit),
      .result   (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hidx_q <= '0;
         tx_q   <= '0;
         cs_n_q <= 1'b1;
         sclk_q <= 1'b0;
         di_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  st_q   <= ST_LEAD;
                  hidx_q <= '0;
                  tx_q   <= word;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  if (hidx_q == HI_W'(LEAD_HALVES - 1)) begin
                     st_q   <= ST_RUN;
                     hidx_q <= '0;
                     cs_n_q <= 1'b0;
                     sclk_q <= 1'b0;
                     di_q   <= 1'b1;          // start bit
                  end else begin
                     hidx_q <= hnext;
                  end
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (last_half) begin
                     st_q   <= ST_IDLE;
                     hidx_q <= '0;
                     cs_n_q <= 1'b1;
                     sclk_q <= 1'b0;
                     di_q   <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     hidx_q <= hnext;
                     if (hnext[0]) begin
                        sclk_q <= 1'b1;
                     end else begin
                        sclk_q <= 1'b0;
                        di_q   <= tx_q[ADDR_W-1];
                        tx_q   <= {tx_q[ADDR_W-2:0], 1'b0};
                     end
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign adc_cs_n = cs_n_q;
   assign adc_sclk = sclk_q;
   assign adc_di   = di_q;

   // R8: the select line is released only together with the result strobe
   assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> done)
      else $error("select released outside the end of a conversion");

   // R8: the result strobe is a single cycle
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done wider than one cycle");

   // R3: serial clock parked low while deselected
   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk)
      else $error("serial clock high while deselected");

   // R4: command line is set up before each rising edge
   assert_di_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_sclk) |-> $stable(adc_di))
      else $error("command line moved with the rising edge");

   // R4: selection starts with the clock low and the start bit present
   assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> (adc_di && !adc_sclk))
      else $error("select fell without start bit set up");

   // R2: an idle request is taken and the line stays deselected at first
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (busy && adc_cs_n))
      else $error("idle request not taken");

   // R9: a transaction only ever ends through the result strobe
   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("busy dropped without done");

endmodule

// File: tb/sadc_host_test.sv
module sadc_host_test;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 8;
   localparam int DIV_W  = 8;
   localparam int DATA_W = 8;
   localparam int CH_W   = 3;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIV_W-1:0]  half_period = '0;
   logic              req_valid = 1'b0;
   logic [CH_W-1:0]   req_ch = '0;
   logic              req_diff = 1'b0;
   logic              busy;
   logic              done;
   logic [DATA_W-1:0] result;
   logic              adc_cs_n;
   logic              adc_sclk;
   logic              adc_di;
   logic              adc_do = 1'b0;

   int checks = 0;
   int fails  = 0;

   // converter model state
   int              cur_h = 1;
   logic [7:0]      m_seed = '0;
   bit              m_started = 0;
   int              m_nad = 0;
   int              m_falls = 0;
   logic [ADDR_W-1:0] m_addr = '0;
   bit              fin_started = 0;
   int              fin_nad = 0;
   logic [ADDR_W-1:0] fin_addr = '0;
   bit              p_cs = 1;
   bit              p_sclk = 0;
   int              ph_len = 0;
   int              ph_bad = 0;
   int              gap_len = 100000;
   int              gap_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sadc_host #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .req_valid(req_valid), .req_ch(req_ch), .req_diff(req_diff),
      .busy(busy), .done(done), .result(result),
      .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_di(adc_di), .adc_do(adc_do)
   );

   function automatic logic [7:0] conv_value(input int pos, input int sgl, input logic [7:0] seed);
      int v;
      v = pos * 37 + sgl * 101;
      return 8'(v) ^ seed;
   endfunction

   function automatic logic [7:0] model_value(input logic [ADDR_W-1:0] a, input logic [7:0] seed);
      int pos;
      pos = int'({a[ADDR_W-3:0], a[ADDR_W-2]});
      return conv_value(pos, int'(a[ADDR_W-1]), seed);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // converter model and line monitor, sampled away from the active edge
   initial begin
      logic [7:0] v;
      forever begin
         @(negedge clk);
         if (adc_cs_n) begin
            if (!p_cs) begin
               if (ph_len != cur_h) ph_bad++;
               fin_started = m_started;
               fin_nad     = m_nad;
               fin_addr    = m_addr;
               gap_len     = 0;
            end
            gap_len++;
            m_started = 0;
            m_nad     = 0;
            m_falls   = 0;
            adc_do    = 1'b0;
         end else begin
            if (p_cs) begin
               if (gap_len < 2 * cur_h) gap_bad++;
               ph_len = 1;
               m_addr = '0;
            end else if (adc_sclk == p_sclk) begin
               ph_len++;
            end else begin
               if (ph_len != cur_h) ph_bad++;
               ph_len = 1;
               if (adc_sclk) begin
                  if (!m_started) begin
                     if (adc_di) m_started = 1;
                  end else if (m_nad < ADDR_W) begin
                     m_addr = {m_addr[ADDR_W-2:0], adc_di};
                     m_nad++;
                  end
               end else begin
                  if (m_started && m_nad == ADDR_W) begin
                     m_falls++;
                     v = model_value(m_addr, m_seed);
                     if (m_falls == 1)
                        adc_do = ~v[DATA_W-1];      // settle cycle: misleading value
                     else if (m_falls <= DATA_W + 1)
                        adc_do = v[DATA_W + 1 - m_falls];
                     else
                        adc_do = 1'b1;
                  end else begin
                     adc_do = 1'b1;
                  end
               end
            end
         end
         p_cs   = adc_cs_n;
         p_sclk = adc_sclk;
      end
   end

   task automatic run_txn(input int ch, input bit diff, input int hp, input logic [7:0] seed,
                          input bit inject, input bit start_now, input bit chain_next);
      int n;
      logic [7:0] expv;
      int exp_addr;
      cur_h = (hp == 0) ? 1 : hp;
      m_seed = seed;
      ph_bad = 0;
      gap_bad = 0;
      if (!start_now) @(negedge clk);
      half_period = DIV_W'(hp);
      req_ch   = CH_W'(ch);
      req_diff = diff;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
      if (inject) begin
         repeat (3 * cur_h + 5) @(negedge clk);
         req_ch = CH_W'(7 - ch);
         req_diff = ~diff;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      #1;
      check(done == 1'b1, "R8 done strobe", int'(done), 1);
      check(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R8 cs up with sclk down",
            int'({adc_cs_n, adc_sclk}), 2);
      expv = conv_value(ch, diff ? 0 : 1, seed);
      check(result == expv, "R7 R6 result MSB first, settle ignored", int'(result), int'(expv));
      check(fin_started == 1, "R4 start bit seen", int'(fin_started), 1);
      exp_addr = ((diff ? 0 : 1) << 3) | ((ch & 1) << 2) | (ch >> 1);
      check(fin_nad == ADDR_W && int'(fin_addr) == exp_addr, "R5 address word",
            int'(fin_addr), exp_addr);
      check(ph_bad == 0, "R3 sclk phase lengths", ph_bad, 0);
      check(gap_bad == 0, "R2 deselect gap", gap_bad, 0);
      if (!chain_next) begin
         @(negedge clk);
         check(done == 1'b0, "R8 done one cycle", int'(done), 0);
         check(result == expv, "R8 result held", int'(result), int'(expv));
         if (inject) begin
            n = 0;
            repeat (2 * cur_h + 4) begin
               @(negedge clk);
               if (busy || !adc_cs_n) n++;
            end
            check(n == 0, "R9 busy request ignored", n, 0);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(adc_cs_n == 1 && adc_sclk == 0 && adc_di == 0 && busy == 0 && done == 0,
            "R1 reset state", int'({adc_cs_n, adc_sclk, adc_di, busy, done}), 16);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(adc_cs_n == 1 && adc_sclk == 0 && adc_di == 0 && busy == 0 && done == 0,
            "R1 after reset", int'({adc_cs_n, adc_sclk, adc_di, busy, done}), 16);

      for (int hp = 0; hp < 4; hp++) begin
         for (int d = 0; d < 2; d++) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
               run_txn(ch, d[0], hp, 8'(ch * 11 + hp * 29 + d * 7 + 3), ch == 3, 0, 0);
            end
         end
      end

      // R9: request made inside the done cycle of the previous transaction
      run_txn(5, 1, 2, 8'hA5, 0, 0, 1);
      run_txn(2, 0, 2, 8'h3C, 0, 1, 1);
      run_txn(7, 1, 2, 8'h81, 0, 1, 0);
      run_txn(6, 0, 1, 8'h00, 0, 0, 1);
      run_txn(1, 1, 1, 8'hFF, 0, 1, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule